// File: doc/BRIEF.md
# Filtered Fault Shutdown for Three-Phase and PFC Gate Drives

This block stands between a three-phase PWM generator and the six gate outputs of an inverter, and between a power-factor-correction PWM source and its single gate output. Each channel has a fault pin of its own. The pin's active sense is selectable. The pin passes through a two-stage synchronizer and then a saturating-counter glitch filter. Once a fault level has lasted the programmed number of clocks, the channel's shutdown latch sets, and every gate of that channel is held at its inactive level.

The latch stays set after the fault pin returns to idle. Only an explicit clear pulse releases it, and a clear has no effect while the filtered fault is still present. When the PFC fault pin is given over to general-purpose use, the PFC channel ignores that pin and is shut down by the motor fault instead. Every gate output has its own polarity bit, so that a gate can be driven high-true or low-true. The inactive level of each gate follows from its polarity bit.

Top module: `gate_kill_guard`

## Requirements
- R1: A fault level must be present at the filter for `filt_len` consecutive clocks before it is qualified. A `filt_len` of 0 selects the default length of 32. A fault pulse that holds for one clock less than the length leaves the gates untouched, and a pulse that holds for exactly the length causes a shutdown.
- R2: If the fault pin is held active, the gates reach their inactive levels on rising edge `L+4` after the pin changes, where L is the effective filter length. With the default length this is edge 36, which is within the 100-clock limit. On edge `L+3` the gates still carry the PWM.
- R3: A qualified motor fault forces all six motor gates to their inactive levels. The motor gate bit order is {WL, WH, VL, VH, UL, UH}, with UH at bit 0. With `pfc_pin_gpio` = 0, a motor fault leaves the PFC gate untouched.
- R4: `mot_flt_pol` and `pfc_flt_pol` select the active level of the fault pins: 1 means the pin is active high, 0 means it is active low. A pin that rests at its idle level never causes a shutdown.
- R5: Each gate output has a polarity bit, where 1 means high-true. The gate output equals the gated drive XOR the inverted polarity bit, so the inactive level of each gate is the complement of its polarity bit.
- R6: A shutdown stays in force after the fault pin returns to idle, until a clear pulse arrives.
- R7: A clear pulse that arrives while the channel's filtered fault is still qualified is ignored, and the gates stay inactive.
- R8: With `pfc_pin_gpio` = 0, a qualified PFC fault forces only the PFC gate inactive. The motor gates keep passing their PWM.
- R9: With `pfc_pin_gpio` = 1, the PFC fault pin is ignored, and a qualified motor fault shuts down both the motor gates and the PFC gate.
- R10: While a channel is not shut down, each gate output carries its PWM input with one clock of latency, with the polarity of R5 applied.
- R11: While reset is asserted, and until the first clock edge after reset is released, every gate output sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mot_pwm_in | input | 6 | Raw motor PWM, 1 = switch on, bit order {WL,WH,VL,VH,UL,UH} |
| pfc_pwm_in | input | 1 | Raw PFC PWM, 1 = switch on |
| mot_flt_pin | input | 1 | Motor fault pin, asynchronous |
| pfc_flt_pin | input | 1 | PFC fault pin, asynchronous |
| mot_flt_pol | input | 1 | Motor fault sense, 1 = active high |
| pfc_flt_pol | input | 1 | PFC fault sense, 1 = active high |
| pfc_pin_gpio | input | 1 | 1 = PFC fault pin unused, motor fault shuts down the PFC |
| filt_len | input | 8 | Filter length in clocks, 0 = default of 32 |
| mot_clr | input | 1 | Clear pulse for the motor shutdown latch |
| pfc_clr | input | 1 | Clear pulse for the PFC shutdown latch |
| mot_out_pol | input | 6 | Per-gate polarity of the motor gates, 1 = high-true |
| pfc_out_pol | input | 1 | Polarity of the PFC gate, 1 = high-true |
| mot_gate_out | output | 6 | Gated motor outputs |
| pfc_gate_out | output | 1 | Gated PFC output |

## Verification
The bench sends fault pulses of exactly L-1 and L clocks at the default length. A filter that is off by one would either pass a short glitch or miss a legal fault. It then samples the gates on edges L+3 and L+4 after a held fault, so an extra register stage in the path, or a missing one, shows up as a latency error. Clears are issued both during the fault and after it. A latch that obeys the clear unconditionally would turn the gates back on into a live fault, and a latch that does not hold would drop out as soon as the pin goes idle. Low-true fault sense, mixed output polarity and the PFC routing mode are each exercised. An inverted sense, a wrong inactive level, or a PFC channel that still listens to its own pin all produce wrong output levels at the ports.

// File: rtl/gk_pkg.sv
package gk_pkg;
  localparam int unsigned GATE_N   = 6;
  localparam int unsigned CNT_W    = 8;
  localparam int unsigned DEF_LEN  = 32;

  typedef enum int unsigned {
    PH_UH = 0, PH_UL = 1, PH_VH = 2, PH_VL = 3, PH_WH = 4, PH_WL = 5
  } phase_idx_e;

  typedef logic [GATE_N-1:0] gate_vec_t;
endpackage

// File: rtl/gk_sync.sv
module gk_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic sense_high,
  output logic fault_lvl
);
  logic meta_q, stab_q;
  logic meta_d;

  // Fault level is formed before the synchronizer so that the reset
  // value 0 means "no fault" for either sense.
  always_comb meta_d = (pin == sense_high);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      stab_q <= meta_q;
    end
  end

  assign fault_lvl = stab_q;
endmodule

// File: rtl/gk_filter.sv
module gk_filter #(
  parameter int unsigned CW      = 8,
  parameter int unsigned DEF_LEN = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault_lvl,
  input  logic [CW-1:0] len_cfg,
  output logic          qual
);
  localparam logic [CW-1:0] DEF_V = CW'(DEF_LEN);
  localparam logic [CW-1:0] ONE_V = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q, cnt_d, len_eff;
  logic          cnt_en;

  always_comb begin
    len_eff = (len_cfg == '0) ? DEF_V : len_cfg;
    cnt_en  = 1'b1;
    if (!fault_lvl)            cnt_d = '0;
    else if (cnt_q < len_eff)  cnt_d = cnt_q + ONE_V;
    else                       cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign qual = (cnt_q >= len_eff);
endmodule

// File: rtl/gk_latch.sv
module gk_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic kill
);
  logic kill_q, kill_d;

  // Set has priority: a clear during a qualified fault is lost.
  always_comb begin
    if (set_i)      kill_d = 1'b1;
    else if (clr_i) kill_d = 1'b0;
    else            kill_d = kill_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kill_q <= 1'b0;
    else        kill_q <= kill_d;
  end

  assign kill = kill_q;
endmodule

// File: rtl/gk_outstage.sv
module gk_outstage #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pwm,
  input  logic         kill,
  input  logic [N-1:0] pol,
  output logic [N-1:0] gate
);
  logic [N-1:0] drv_q, drv_d;

  for (genvar g = 0; g < N; g++) begin : g_lane
    always_comb drv_d[g] = pwm[g] & ~kill;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drv_q[g] <= 1'b0;
      else        drv_q[g] <= drv_d[g];
    end

    assign gate[g] = drv_q[g] ^ ~pol[g];
  end
endmodule

// File: rtl/gate_kill_guard.sv
module gate_kill_guard
  import gk_pkg::*;
#(
  parameter int unsigned FW   = CNT_W,
  parameter int unsigned DLEN = DEF_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GATE_N-1:0] mot_pwm_in,
  input  logic              pfc_pwm_in,
  input  logic              mot_flt_pin,
  input  logic              pfc_flt_pin,
  input  logic              mot_flt_pol,
  input  logic              pfc_flt_pol,
  input  logic              pfc_pin_gpio,
  input  logic [FW-1:0]     filt_len,
  input  logic              mot_clr,
  input  logic              pfc_clr,
  input  logic [GATE_N-1:0] mot_out_pol,
  input  logic              pfc_out_pol,
  output logic [GATE_N-1:0] mot_gate_out,
  output logic              pfc_gate_out
);
  logic mot_lvl, pfc_lvl;
  logic mot_qual, pfc_qual;
  logic pfc_set, pfc_src_qual;
  logic mot_kill, pfc_kill;

  gk_sync i_mot_sync (.clk(clk), .rst_n(rst_n), .pin(mot_flt_pin),
                      .sense_high(mot_flt_pol), .fault_lvl(mot_lvl));
  gk_sync i_pfc_sync (.clk(clk), .rst_n(rst_n), .pin(pfc_flt_pin),
                      .sense_high(pfc_flt_pol), .fault_lvl(pfc_lvl));

  gk_filter #(.CW(FW), .DEF_LEN(DLEN)) i_mot_filt (
    .clk(clk), .rst_n(rst_n), .fault_lvl(mot_lvl), .len_cfg(filt_len), .qual(mot_qual));
  gk_filter #(.CW(FW), .DEF_LEN(DLEN)) i_pfc_filt (
    .clk(clk), .rst_n(rst_n), .fault_lvl(pfc_lvl), .len_cfg(filt_len), .qual(pfc_qual));

  // Source selection for the PFC shutdown latch.
  always_comb begin
    pfc_src_qual = pfc_pin_gpio ? mot_qual : pfc_qual;
    pfc_set      = pfc_src_qual;
  end

  gk_latch i_mot_latch (.clk(clk), .rst_n(rst_n), .set_i(mot_qual),
                        .clr_i(mot_clr), .kill(mot_kill));
  gk_latch i_pfc_latch (.clk(clk), .rst_n(rst_n), .set_i(pfc_set),
                        .clr_i(pfc_clr), .kill(pfc_kill));

  gk_outstage #(.N(GATE_N)) i_mot_out (
    .clk(clk), .rst_n(rst_n), .pwm(mot_pwm_in), .kill(mot_kill),
    .pol(mot_out_pol), .gate(mot_gate_out));
  gk_outstage #(.N(1)) i_pfc_out (
    .clk(clk), .rst_n(rst_n), .pwm(pfc_pwm_in), .kill(pfc_kill),
    .pol(pfc_out_pol), .gate(pfc_gate_out));
endmodule

// File: rtl/gk_guard_chk.sv
module gk_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] mot_pwm_in,
  input logic [5:0] mot_out_pol,
  input logic [5:0] mot_gate_out,
  input logic       pfc_out_pol,
  input logic       pfc_gate_out,
  input logic       pfc_pin_gpio,
  input logic       mot_clr,
  input logic       mot_qual,
  input logic       mot_kill,
  input logic       pfc_kill
);
  AST_RISE_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mot_kill) |-> $past(mot_qual)); // R1
  AST_MOT_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    mot_kill |=> (mot_gate_out == ~mot_out_pol)); // R3
  AST_PFC_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pfc_kill |=> (pfc_gate_out == ~pfc_out_pol)); // R8
  AST_KILL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mot_kill && !mot_clr) |=> mot_kill); // R6
  AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mot_kill && mot_qual) |=> mot_kill); // R7
  AST_ROUTE_MOT_TO_PFC: assert property (@(posedge clk) disable iff (!rst_n)
    (pfc_pin_gpio && mot_qual) |=> pfc_kill); // R9
  AST_PFC_PIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pfc_pin_gpio && !mot_qual && !pfc_kill) |=> !pfc_kill); // R9
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mot_kill |=> (mot_gate_out == ($past(mot_pwm_in) ^ ~mot_out_pol))); // R10
endmodule

bind gate_kill_guard gk_guard_chk i_gk_guard_chk (
  .clk(clk), .rst_n(rst_n), .mot_pwm_in(mot_pwm_in), .mot_out_pol(mot_out_pol),
  .mot_gate_out(mot_gate_out), .pfc_out_pol(pfc_out_pol), .pfc_gate_out(pfc_gate_out),
  .pfc_pin_gpio(pfc_pin_gpio), .mot_clr(mot_clr), .mot_qual(mot_qual),
  .mot_kill(mot_kill), .pfc_kill(pfc_kill));

// File: tb/test_gate_kill_guard.sv
module test_gate_kill_guard;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] mot_pwm_in;
  logic       pfc_pwm_in;
  logic       mot_flt_pin, pfc_flt_pin, mot_flt_pol, pfc_flt_pol, pfc_pin_gpio;
  logic [7:0] filt_len;
  logic       mot_clr, pfc_clr;
  logic [5:0] mot_out_pol;
  logic       pfc_out_pol;
  logic [5:0] mot_gate_out;
  logic       pfc_gate_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  gate_kill_guard i_gate_kill_guard (
    .clk(clk), .rst_n(rst_n), .mot_pwm_in(mot_pwm_in), .pfc_pwm_in(pfc_pwm_in),
    .mot_flt_pin(mot_flt_pin), .pfc_flt_pin(pfc_flt_pin), .mot_flt_pol(mot_flt_pol),
    .pfc_flt_pol(pfc_flt_pol), .pfc_pin_gpio(pfc_pin_gpio), .filt_len(filt_len),
    .mot_clr(mot_clr), .pfc_clr(pfc_clr), .mot_out_pol(mot_out_pol),
    .pfc_out_pol(pfc_out_pol), .mot_gate_out(mot_gate_out), .pfc_gate_out(pfc_gate_out));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  function automatic logic [7:0] mot_pass();
    return {2'b00, mot_pwm_in ^ ~mot_out_pol};
  endfunction
  function automatic logic [7:0] mot_off();
    return {2'b00, ~mot_out_pol};
  endfunction
  function automatic logic [7:0] pfc_pass();
    return {7'd0, pfc_pwm_in ^ ~pfc_out_pol};
  endfunction
  function automatic logic [7:0] pfc_off();
    return {7'd0, ~pfc_out_pol};
  endfunction

  task automatic do_reset(input logic [7:0] len, input logic msense);
    rst_n        = 1'b0;
    mot_pwm_in   = 6'b011001;
    pfc_pwm_in   = 1'b1;
    mot_flt_pol  = msense;
    mot_flt_pin  = ~msense;
    pfc_flt_pol  = 1'b1;
    pfc_flt_pin  = 1'b0;
    pfc_pin_gpio = 1'b0;
    filt_len     = len;
    mot_clr      = 1'b0;
    pfc_clr      = 1'b0;
    mot_out_pol  = 6'b101010;
    pfc_out_pol  = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    mot_out_pol = 6'b110100;
    pfc_out_pol = 1'b1;
    mot_pwm_in  = 6'b111111;
    step(2);
    check("R11 motor gates in reset", {2'b00, mot_gate_out}, mot_off());
    check("R11 pfc gate in reset", {7'd0, pfc_gate_out}, pfc_off());
  endtask

  task automatic t_pass();
    do_reset(8'd4, 1'b1);
    check("R10 pass pattern A", {2'b00, mot_gate_out}, mot_pass());
    mot_pwm_in = 6'b100110; step(1);
    check("R10 pass pattern B one clock", {2'b00, mot_gate_out}, mot_pass());
    mot_out_pol = 6'b000000; mot_pwm_in = 6'b010101; step(1);
    check("R5 all low-true polarity", {2'b00, mot_gate_out}, {2'b00, 6'b101010});
    mot_out_pol = 6'b111111; step(1);
    check("R5 all high-true polarity", {2'b00, mot_gate_out}, {2'b00, 6'b010101});
    check("R10 pfc pass", {7'd0, pfc_gate_out}, pfc_pass());
  endtask

  task automatic t_default_filter();
    do_reset(8'd0, 1'b1);
    mot_flt_pin = 1'b1; step(31); mot_flt_pin = 1'b0; step(40);
    check("R1 31-clock glitch rejected", {2'b00, mot_gate_out}, mot_pass());
    mot_flt_pin = 1'b1; step(32); mot_flt_pin = 1'b0; step(40);
    check("R1 32-clock pulse accepted", {2'b00, mot_gate_out}, mot_off());
    do_reset(8'd0, 1'b1);
    mot_flt_pin = 1'b1; step(35);
    check("R2 still driving on edge L+3", {2'b00, mot_gate_out}, mot_pass());
    step(1);
    check("R2 inactive on edge L+4", {2'b00, mot_gate_out}, mot_off());
    check("R3 pfc untouched by motor fault", {7'd0, pfc_gate_out}, pfc_pass());
  endtask

  task automatic t_sense();
    do_reset(8'd4, 1'b0);
    step(20);
    check("R4 idle-high low-true pin harmless", {2'b00, mot_gate_out}, mot_pass());
    mot_flt_pin = 1'b0; step(10);
    check("R4 low-true pin shuts down", {2'b00, mot_gate_out}, mot_off());
  endtask

  task automatic t_latch_clear();
    do_reset(8'd4, 1'b1);
    mot_flt_pin = 1'b1; step(10);
    mot_clr = 1'b1; step(1); mot_clr = 1'b0; step(3);
    check("R7 clear during fault ignored", {2'b00, mot_gate_out}, mot_off());
    mot_flt_pin = 1'b0; step(6);
    check("R6 shutdown held after fault idle", {2'b00, mot_gate_out}, mot_off());
    mot_clr = 1'b1; step(1); mot_clr = 1'b0; step(1);
    check("R6 clear releases gates", {2'b00, mot_gate_out}, mot_pass());
  endtask

  task automatic t_pfc();
    do_reset(8'd4, 1'b1);
    pfc_flt_pin = 1'b1; step(10);
    check("R8 pfc gate inactive", {7'd0, pfc_gate_out}, pfc_off());
    check("R8 motor gates still pass", {2'b00, mot_gate_out}, mot_pass());
  endtask

  task automatic t_route();
    do_reset(8'd4, 1'b1);
    pfc_pin_gpio = 1'b1;
    pfc_flt_pin  = 1'b1; step(12);
    check("R9 pfc pin ignored in gpio mode", {7'd0, pfc_gate_out}, pfc_pass());
    mot_flt_pin = 1'b1; step(10);
    check("R9 motor fault kills pfc", {7'd0, pfc_gate_out}, pfc_off());
    check("R3 motor gates inactive", {2'b00, mot_gate_out}, mot_off());
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_pass();
    t_default_filter();
    t_sense();
    t_latch_clear();
    t_pfc();
    t_route();
    finish_run();
  end
endmodule